// File: doc/BRIEF.md
# External Interrupt Pad Conditioner with Sticky Request

This block takes one asynchronous external interrupt pad, brings it into the clock domain and qualifies it with one of four sense modes. The qualified event sets a sticky flag. The flag drives a level-high request toward a downstream interrupt controller, so the controller sees an active-high level whichever polarity or edge the pad uses. Software clears the flag by writing a one to the pending register. When the flag is set and the enable bit is also set, the block raises a wake request.

A small synchronous register port gives access to three registers: sense mode, pending and enable. Reads return data one cycle after the access is sampled. Offsets that map to no register read as zero and ignore writes.

Top module: `nmi_cond_top`

## Requirements
- R1: After synchronous reset, `irq_o` and `wake_o` are 0, `rd_data_o` is 0, the sense mode is 3 (rising edge) and the enable bit is 1.
- R2: The sense mode is bits [1:0] of the register at offset 0x0C: 0 = pad low level, 1 = falling edge, 2 = pad high level, 3 = rising edge.
- R3: The pad passes through a two-flop synchroniser. After the pad changes, `irq_o` rises on the third rising clock edge, counting from the first edge that samples the new value.
- R4: The sticky flag stays set until it is cleared, and `irq_o` is active high in every sense mode.
- R5: Writing 1 to bit 0 at offset 0x10 clears the flag. Writing 0 to that bit leaves the flag unchanged.
- R6: In the two level modes the flag is set again on every cycle that the level stays asserted, so a clear holds only once the pad is inactive.
- R7: When a set event and a clear write fall in the same cycle, the flag ends up set.
- R8: A read of bit 0 at offset 0x10 returns the flag AND the enable bit (bit 0 at offset 0x40). Offset 0x0C reads back the mode and offset 0x40 reads back the enable. Any other offset reads 0. Read data is valid one cycle after the access.
- R9: `wake_o` equals the flag AND the enable bit, and it is registered alongside `irq_o`.
- R10: A write to the mode register blocks edge detection in the following cycle, so a mode change cannot produce a spurious edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pad_i | input | 1 | Asynchronous external interrupt pad |
| acc_en_i | input | 1 | Register access strobe |
| acc_we_i | input | 1 | 1 = write, 0 = read |
| acc_addr_i | input | 8 | Byte offset |
| acc_wdata_i | input | 32 | Write data |
| rd_data_o | output | 32 | Registered read data |
| irq_o | output | 1 | Level-high request to the downstream controller |
| wake_o | output | 1 | Wake request (flag AND enable) |

## Verification
A corrupted sticky flag is visible on `irq_o` in the very next cycle and stays visible, because nothing but a clear write or a new event changes it. A wrong synchroniser depth or wrong edge history shifts the rise of `irq_o` by a cycle, or makes it fire where no event was due, and a cycle-exact comparison catches this at once. A wrong stored mode or enable shows up either on the next matching pad event or on a read-back one cycle after the access.

// File: rtl/nmi_cond_pkg.sv
package nmi_cond_pkg;
  typedef enum logic [1:0] {
    SENSE_LOW  = 2'd0,
    SENSE_FALL = 2'd1,
    SENSE_HIGH = 2'd2,
    SENSE_RISE = 2'd3
  } sense_e;

  function automatic logic is_edge(input sense_e m);
    return (m == SENSE_FALL) || (m == SENSE_RISE);
  endfunction
endpackage

// File: rtl/nmi_sync.sv
module nmi_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[0] <= 1'b0;
          else     chain_q[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[i] <= 1'b0;
          else     chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/nmi_sense.sv
module nmi_sense
  import nmi_cond_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   pad_s_i,
  input  sense_e mode_i,
  input  logic   hist_clr_i,
  output logic   evt_o
);
  logic prev_q;
  logic hist_q;
  logic rise_w, fall_w;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      hist_q <= 1'b0;
    end else begin
      prev_q <= pad_s_i;
      hist_q <= !hist_clr_i;
    end
  end

  assign rise_w = hist_q &&  pad_s_i && !prev_q;
  assign fall_w = hist_q && !pad_s_i &&  prev_q;

  always_comb begin
    unique case (mode_i)
      SENSE_LOW:  evt_o = !pad_s_i;
      SENSE_FALL: evt_o = fall_w;
      SENSE_HIGH: evt_o = pad_s_i;
      SENSE_RISE: evt_o = rise_w;
      default:    evt_o = 1'b0;
    endcase
  end

  AST_NO_EDGE_AFTER_MODE: assert property (@(posedge clk) disable iff (rst)
    ($past(hist_clr_i) && is_edge(mode_i)) |-> !evt_o); // R10
endmodule

// File: rtl/nmi_latch.sv
module nmi_latch (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk) begin
    if (rst)        q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    set_i |=> q_o); // R7
  AST_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!set_i && !clr_i) |=> (q_o == $past(q_o))); // R4
  AST_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !set_i) |=> !q_o); // R5
endmodule

// File: rtl/nmi_regs.sv
module nmi_regs
  import nmi_cond_pkg::*;
#(
  parameter int          ADDR_W   = 8,
  parameter int          DATA_W   = 32,
  parameter logic [7:0]  OFF_MODE = 8'h0C,
  parameter logic [7:0]  OFF_PEND = 8'h10,
  parameter logic [7:0]  OFF_EN   = 8'h40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_en_i,
  input  logic              acc_we_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic [DATA_W-1:0] acc_wdata_i,
  input  logic              flag_i,
  output logic [DATA_W-1:0] rd_data_o,
  output sense_e            mode_o,
  output logic              en_o,
  output logic              clr_o,
  output logic              mode_wr_o
);
  localparam int PAD_W = DATA_W - 2;

  logic hit_mode, hit_pend, hit_en, wr;
  logic unused_wdata;

  assign unused_wdata = ^acc_wdata_i[DATA_W-1:2];
  assign wr        = acc_en_i && acc_we_i;
  assign hit_mode  = (acc_addr_i == ADDR_W'(OFF_MODE));
  assign hit_pend  = (acc_addr_i == ADDR_W'(OFF_PEND));
  assign hit_en    = (acc_addr_i == ADDR_W'(OFF_EN));
  assign mode_wr_o = wr && hit_mode;
  assign clr_o     = wr && hit_pend && acc_wdata_i[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_o <= SENSE_RISE;
      en_o   <= 1'b1;
    end else begin
      if (mode_wr_o)     mode_o <= sense_e'(acc_wdata_i[1:0]);
      if (wr && hit_en)  en_o   <= acc_wdata_i[0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data_o <= '0;
    end else if (acc_en_i && !acc_we_i) begin
      if (hit_mode)      rd_data_o <= {{PAD_W{1'b0}}, mode_o};
      else if (hit_pend) rd_data_o <= {{(DATA_W-1){1'b0}}, flag_i && en_o};
      else if (hit_en)   rd_data_o <= {{(DATA_W-1){1'b0}}, en_o};
      else               rd_data_o <= '0;
    end
  end
endmodule

// File: rtl/nmi_cond_top.sv
module nmi_cond_top
  import nmi_cond_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pad_i,
  input  logic              acc_en_i,
  input  logic              acc_we_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic [DATA_W-1:0] acc_wdata_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              irq_o,
  output logic              wake_o
);
  logic   pad_s, evt, clr, mode_wr, en, flag;
  sense_e mode;

  nmi_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_i(pad_i), .q_o(pad_s)
  );

  nmi_sense u_sense (
    .clk(clk), .rst(rst), .pad_s_i(pad_s), .mode_i(mode),
    .hist_clr_i(mode_wr), .evt_o(evt)
  );

  nmi_latch u_latch (
    .clk(clk), .rst(rst), .set_i(evt), .clr_i(clr), .q_o(flag)
  );

  nmi_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .acc_en_i(acc_en_i), .acc_we_i(acc_we_i),
    .acc_addr_i(acc_addr_i), .acc_wdata_i(acc_wdata_i), .flag_i(flag),
    .rd_data_o(rd_data_o), .mode_o(mode), .en_o(en), .clr_o(clr),
    .mode_wr_o(mode_wr)
  );

  assign irq_o = flag;

  always_ff @(posedge clk) begin
    if (rst) wake_o <= 1'b0;
    else     wake_o <= (evt || (flag && !clr)) && (acc_en_i && acc_we_i &&
                       acc_addr_i == ADDR_W'(8'h40) ? acc_wdata_i[0] : en);
  end

  AST_WAKE_NEEDS_IRQ: assert property (@(posedge clk) disable iff (rst)
    wake_o |-> irq_o); // R9
endmodule

// File: tb/tb_nmi_cond_top.sv
module tb_nmi_cond_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        pad;
  logic        a_en, a_we;
  logic [7:0]  a_addr;
  logic [31:0] a_wd;
  logic [31:0] rd;
  logic        irq, wake;
  int          n_chk = 0;
  int          n_err = 0;

  always #4 clk = ~clk;

  nmi_cond_top dut (
    .clk(clk), .rst(rst), .pad_i(pad), .acc_en_i(a_en), .acc_we_i(a_we),
    .acc_addr_i(a_addr), .acc_wdata_i(a_wd), .rd_data_o(rd),
    .irq_o(irq), .wake_o(wake)
  );

  // Reference model built from the requirements
  logic       m_s1, m_s2, m_prev, m_hist, m_flag, m_en, m_wake, m_rdv;
  logic [1:0] m_mode;
  logic [31:0] m_rd;

  function automatic logic sense_evt(input logic [1:0] md, input logic s,
                                     input logic p, input logic h);
    case (md)
      2'd0: return !s;
      2'd1: return h && !s && p;
      2'd2: return s;
      default: return h && s && !p;
    endcase
  endfunction

  always @(posedge clk) begin
    logic ev, clr, mw, ew, nen;
    if (rst) begin
      m_s1 <= 0; m_s2 <= 0; m_prev <= 0; m_hist <= 0; m_flag <= 0;
      m_en <= 1; m_mode <= 2'd3; m_wake <= 0; m_rd <= 0; m_rdv <= 0;
    end else begin
      ev  = sense_evt(m_mode, m_s2, m_prev, m_hist);
      clr = a_en && a_we && a_addr == 8'h10 && a_wd[0];
      mw  = a_en && a_we && a_addr == 8'h0C;
      ew  = a_en && a_we && a_addr == 8'h40;
      nen = ew ? a_wd[0] : m_en;
      m_s1 <= pad; m_s2 <= m_s1; m_prev <= m_s2; m_hist <= !mw;
      m_flag <= ev || (m_flag && !clr);
      m_wake <= (ev || (m_flag && !clr)) && nen;
      m_en <= nen;
      if (mw) m_mode <= a_wd[1:0];
      m_rdv <= a_en && !a_we;
      if (a_en && !a_we) begin
        case (a_addr)
          8'h0C:   m_rd <= {30'd0, m_mode};
          8'h10:   m_rd <= {31'd0, m_flag && m_en};
          8'h40:   m_rd <= {31'd0, m_en};
          default: m_rd <= 32'd0;
        endcase
      end
    end
  end

  task automatic chk(input logic ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cmp_model();
    chk(irq == m_flag, "R4 irq", {31'd0, irq}, {31'd0, m_flag});
    chk(wake == m_wake, "R9 wake", {31'd0, wake}, {31'd0, m_wake});
    if (m_rdv) chk(rd == m_rd, "R8 rdata", rd, m_rd);
  endtask

  // Apply one cycle of stimulus, then compare at the next falling edge
  task automatic cyc(input logic p, input logic en, input logic we,
                     input logic [7:0] ad, input logic [31:0] wd);
    pad = p; a_en = en; a_we = we; a_addr = ad; a_wd = wd;
    @(negedge clk);
    cmp_model();
  endtask

  task automatic idle(input logic p); cyc(p, 0, 0, 8'h00, 0); endtask
  task automatic wr(input logic p, input logic [7:0] ad, input logic [31:0] wd);
    cyc(p, 1, 1, ad, wd);
  endtask
  task automatic rdr(input logic p, input logic [7:0] ad); cyc(p, 1, 0, ad, 0); endtask

  initial begin
    #1000000;
    n_err++; n_chk++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    rst = 1; pad = 0; a_en = 0; a_we = 0; a_addr = 0; a_wd = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(irq == 0 && wake == 0 && rd == 0, "R1 outputs", {30'd0, irq, wake}, 0);
    rdr(0, 8'h0C); chk(rd == 32'd3, "R1 mode", rd, 3);
    rdr(0, 8'h40); chk(rd == 32'd1, "R1 enable", rd, 1);

    // R3 latency in rising mode
    idle(1); idle(1);
    chk(irq == 0, "R3 early", {31'd0, irq}, 0);
    idle(1);
    chk(irq == 1, "R3 third edge", {31'd0, irq}, 1);
    idle(0); idle(0); idle(0);
    chk(irq == 1, "R4 sticky", {31'd0, irq}, 1);
    // R5 write 0 ignored, write 1 clears
    wr(0, 8'h10, 32'h0);
    chk(irq == 1, "R5 write zero", {31'd0, irq}, 1);
    wr(0, 8'h10, 32'h1);
    chk(irq == 0, "R5 clear", {31'd0, irq}, 0);

    // R2/R6 level high: clear does not hold while pad high
    wr(0, 8'h0C, 32'h2);
    idle(1); idle(1); idle(1);
    wr(1, 8'h10, 32'h1);
    chk(irq == 1, "R6 level reasserts", {31'd0, irq}, 1);
    idle(0); idle(0); idle(0);
    wr(0, 8'h10, 32'h1);
    chk(irq == 0, "R6 clear holds", {31'd0, irq}, 0);
    // R2 level low
    wr(0, 8'h0C, 32'h0); idle(0);
    chk(irq == 1, "R2 level low", {31'd0, irq}, 1);
    idle(1); idle(1); idle(1); wr(1, 8'h10, 32'h1);
    chk(irq == 0, "R2 low released", {31'd0, irq}, 0);

    // R7 falling edge coincides with clear write
    wr(1, 8'h0C, 32'h1); idle(1); idle(1); idle(1);
    idle(0); idle(0);
    wr(0, 8'h10, 32'h1);
    chk(irq == 1, "R7 set wins", {31'd0, irq}, 1);
    wr(0, 8'h10, 32'h1);
    chk(irq == 0, "R7 later clear", {31'd0, irq}, 0);

    // R10 mode write alongside an edge: suppressed
    idle(1);
    wr(1, 8'h0C, 32'h3);
    idle(1); idle(1);
    chk(irq == 0, "R10 no spurious edge", {31'd0, irq}, 0);

    // R8/R9 enable gating
    idle(0); idle(0); idle(1); idle(1); idle(1);
    wr(1, 8'h40, 32'h0); idle(1);
    chk(wake == 0 && irq == 1, "R9 wake gated", {30'd0, irq, wake}, 32'h2);
    rdr(1, 8'h10); chk(rd == 0, "R8 pending gated", rd, 0);
    wr(1, 8'h40, 32'h1); rdr(1, 8'h10);
    chk(rd == 1, "R8 pending read", rd, 1);
    rdr(1, 8'h24); chk(rd == 0, "R8 unmapped", rd, 0);

    // Random phase
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] ad;
      int sel;
      sel = $urandom_range(0, 3);
      ad = (sel == 0) ? 8'h0C : (sel == 1) ? 8'h10 : (sel == 2) ? 8'h40 : 8'($urandom);
      if ($urandom_range(0, 3) == 0)
        cyc($urandom_range(0, 5) == 0 ? !pad : pad, 1, $urandom_range(0, 1) == 1,
            ad, $urandom);
      else
        idle($urandom_range(0, 5) == 0 ? !pad : pad);
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule